// File: doc/BRIEF.md
# Unprivileged Signed Halfword Load Unit

This unit executes one load instruction at a time. The load reads a halfword at user privilege and writes the sign-extended value to a destination register. It takes a 32-bit instruction word over a valid/ready port and recognises three bit layouts:

- a post-indexed form with an 8-bit immediate offset;
- a post-indexed form whose offset is an index register;
- a base-plus-immediate form with no writeback.

The unit reads the base and index registers through two combinational read ports on an external register file. It works out the access address and issues one halfword read on a request/ready memory port. It then drives a destination write and, for the post-indexed forms, a base writeback.

Instructions that the unit must not execute end with a one-cycle undefined-instruction pulse. These are register-overlap cases, a destination of 15, hypervisor mode, and unrecognised or literal-form words. Such an instruction makes no memory access and no register write. An instruction whose condition-pass bit is low retires as a no-op.

Back-pressure works as follows:

- `instr_ready` is high only while the unit is idle. A word is taken on the first edge where `instr_valid` and `instr_ready` are both high.
- Once `mem_req_valid` rises, it stays high with a steady address until an edge sees `mem_req_ready` high.
- The response is a single-cycle `mem_rsp_valid` pulse. It cannot be stalled.

Top module: `ushl_load_unit`

## Requirements
- R1: After reset the unit is idle: `instr_ready` is 1, and `mem_req_valid`, `dst_we`, `base_we`, `undef_instr` and `retire` are all 0.
- R2: Immediate post-indexed form. Bit layout:
  - bits [31:28] are not 1111, bits [27:25]=000, bit 24=0, and bits 22, 21 and 20 are all 1;
  - bits [7:4]=1111;
  - bits [19:16] hold the base, bits [15:12] the destination, and the offset is {bits[11:8], bits[3:0]} zero-extended;
  - bit 23 selects add (1) or subtract (0).

  The access address is the unmodified base value, and the base register is written with base plus or minus the offset.
- R3: Register post-indexed form. It is identical to R2 except that bit 22=0 and bits [11:8]=0000. The offset is the value of the register named by bits [3:0]. The address and writeback rules are those of R2.
- R4: Offset form. Bit layout:
  - bits [31:20]=1111_1001_0011 and bits [11:8]=1110;
  - bits [19:16] hold the base, which must not be 1111; bits [15:12] the destination; bits [7:0] the immediate.

  The address is base plus the zero-extended immediate, always added, and `base_we` stays 0.
- R5: `dst_data` is the returned halfword sign-extended to 32 bits. It is written to the destination register.
- R6: Every memory request carries `mem_req_unpriv`=1.
- R7: These cases raise `undef_instr` for one cycle and make no memory request and no register write:
  - hypervisor mode;
  - in R2/R3 forms, a destination of 15, a base of 15, or base equal to destination;
  - in the R3 form, an index of 15;
  - in the R4 form, a destination of 15.
- R8: With the condition-pass bit low, the instruction retires with no request, no write and no undefined pulse.
- R9: A word matching none of the R2–R4 layouts raises `undef_instr` and makes no access. This includes the R4 layout with base 1111.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address hold unchanged into the next cycle.
- R11: `dst_we` is 1 exactly in the cycle after `mem_rsp_valid`. `base_we` is 1 in that same cycle for the post-indexed forms only.
- R12: `instr_ready` is 0 from acceptance until the instruction retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit idle, word may be taken |
| instr_word | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition check result for the offered word |
| hyp_mode | input | 1 | Processor is at hypervisor level |
| rf_base_idx | output | 4 | Base register read index |
| rf_base_data | input | XLEN | Base register value |
| rf_index_idx | output | 4 | Index register read index |
| rf_index_data | input | XLEN | Index register value |
| mem_req_valid | output | 1 | Halfword read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | XLEN | Byte address of the halfword |
| mem_req_unpriv | output | 1 | User-privilege access attribute |
| mem_rsp_valid | input | 1 | Read data returned (single cycle) |
| mem_rsp_data | input | HALF_W | Returned halfword |
| dst_we | output | 1 | Destination register write enable |
| dst_idx | output | 4 | Destination register index |
| dst_data | output | XLEN | Sign-extended load value |
| base_we | output | 1 | Base writeback enable |
| base_idx | output | 4 | Base register index for writeback |
| base_data | output | XLEN | Updated base value |
| undef_instr | output | 1 | Undefined-instruction pulse |
| retire | output | 1 | Instruction finished (pulse) |

## Verification
The assertions rely on three things about the environment:

- the memory side returns exactly one `mem_rsp_valid` pulse for each accepted request, and never at any other time;
- the register read data follows its index within the same cycle;
- `cond_pass` and `hyp_mode` are valid alongside `instr_valid`.

The bench's responder asserts the response only on the cycle after it has seen a handshake. It models the register file as a pure function of the index. It holds the side inputs steady for the whole time a word is offered. Under these conditions, a response always lands while the unit is waiting for it.

// File: rtl/ushl_pkg.sv
package ushl_pkg;
  localparam int RIDX_W = 4;
  localparam int IMM_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_WAIT,
    ST_WRITE
  } state_e;

  typedef struct packed {
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] base;
    logic [RIDX_W-1:0] idx;
    logic [IMM_W-1:0]  imm;
    logic              add;
    logic              post;
    logic              use_reg;
    logic              unpred;
  } dec_t;
endpackage

// File: rtl/ushl_decode.sv
module ushl_decode
  import ushl_pkg::*;
(
  input  logic [31:0] word,
  output dec_t        dec
);
  logic arm_shape, hit_pimm, hit_preg, hit_oimm;
  logic [RIDX_W-1:0] rd, rb, ri;
  logic overlap;

  always_comb begin
    rd = word[15:12];
    rb = word[19:16];
    ri = word[3:0];

    arm_shape = (word[31:28] != 4'hF) && (word[27:25] == 3'b000) && !word[24]
              && word[21] && word[20] && (word[7:4] == 4'hF);
    hit_pimm  = arm_shape && word[22];
    hit_preg  = arm_shape && !word[22] && (word[11:8] == 4'h0);
    hit_oimm  = (word[31:20] == 12'hF93) && (word[11:8] == 4'hE) && (rb != 4'hF);

    overlap   = (rd == 4'hF) || (rb == 4'hF) || (rb == rd);

    dec.dst     = rd;
    dec.base    = rb;
    dec.idx     = ri;
    dec.imm     = hit_oimm ? word[7:0] : {word[11:8], word[3:0]};
    dec.add     = hit_oimm || word[23];
    dec.post    = hit_pimm || hit_preg;
    dec.use_reg = hit_preg;

    if (hit_pimm)      dec.unpred = overlap;
    else if (hit_preg) dec.unpred = overlap || (ri == 4'hF);
    else if (hit_oimm) dec.unpred = (rd == 4'hF);
    else               dec.unpred = 1'b1;
  end
endmodule

// File: rtl/ushl_agen.sv
module ushl_agen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 8
) (
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  idx_val,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_reg,
  input  logic             add,
  input  logic             post,
  output logic [XLEN-1:0]  acc_addr,
  output logic [XLEN-1:0]  wb_val
);
  localparam int PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] moved;

  always_comb begin
    offset   = use_reg ? idx_val : {{PAD_W{1'b0}}, imm};
    moved    = add ? (base_val + offset) : (base_val - offset);
    acc_addr = post ? base_val : moved;
    wb_val   = moved;
  end
endmodule

// File: rtl/ushl_sext.sv
module ushl_sext #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  generate
    if (OUT_W > IN_W) begin : g_ext
      assign dout = {{(OUT_W-IN_W){din[IN_W-1]}}, din};
    end else begin : g_pass
      assign dout = din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ushl_load_unit.sv
module ushl_load_unit
  import ushl_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [31:0]       instr_word,
  input  logic              cond_pass,
  input  logic              hyp_mode,
  output logic [3:0]        rf_base_idx,
  input  logic [XLEN-1:0]   rf_base_data,
  output logic [3:0]        rf_index_idx,
  input  logic [XLEN-1:0]   rf_index_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic              mem_req_unpriv,
  input  logic              mem_rsp_valid,
  input  logic [HALF_W-1:0] mem_rsp_data,
  output logic              dst_we,
  output logic [3:0]        dst_idx,
  output logic [XLEN-1:0]   dst_data,
  output logic              base_we,
  output logic [3:0]        base_idx,
  output logic [XLEN-1:0]   base_data,
  output logic              undef_instr,
  output logic              retire
);
  state_e            state;
  logic [31:0]       word_q;
  logic              cond_q, hyp_q;
  logic [XLEN-1:0]   addr_q, wb_q;
  logic [HALF_W-1:0] half_q;
  dec_t              dec;
  logic [XLEN-1:0]   acc_addr, wb_val;
  logic              fault;

  ushl_decode u_dec (
    .word (word_q),
    .dec  (dec)
  );

  ushl_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agen (
    .base_val (rf_base_data),
    .idx_val  (rf_index_data),
    .imm      (dec.imm),
    .use_reg  (dec.use_reg),
    .add      (dec.add),
    .post     (dec.post),
    .acc_addr (acc_addr),
    .wb_val   (wb_val)
  );

  ushl_sext #(.IN_W(HALF_W), .OUT_W(XLEN)) u_sext (
    .din  (half_q),
    .dout (dst_data)
  );

  assign fault = dec.unpred || hyp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      word_q <= '0;
      cond_q <= 1'b0;
      hyp_q  <= 1'b0;
      addr_q <= '0;
      wb_q   <= '0;
      half_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (instr_valid) begin
          word_q <= instr_word;
          cond_q <= cond_pass;
          hyp_q  <= hyp_mode;
          state  <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!cond_q || fault) begin
            state <= ST_IDLE;
          end else begin
            addr_q <= acc_addr;
            wb_q   <= wb_val;
            state  <= ST_REQ;
          end
        end
        ST_REQ: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          half_q <= mem_rsp_data;
          state  <= ST_WRITE;
        end
        ST_WRITE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign instr_ready    = (state == ST_IDLE);
  assign rf_base_idx    = dec.base;
  assign rf_index_idx   = dec.idx;
  assign mem_req_valid  = (state == ST_REQ);
  assign mem_req_addr   = addr_q;
  assign mem_req_unpriv = 1'b1;
  assign dst_we         = (state == ST_WRITE);
  assign dst_idx        = dec.dst;
  assign base_we        = (state == ST_WRITE) && dec.post;
  assign base_idx       = dec.base;
  assign base_data      = wb_q;
  assign undef_instr    = (state == ST_CHECK) && cond_q && fault;
  assign retire         = ((state == ST_CHECK) && (!cond_q || fault))
                        || (state == ST_WRITE);
endmodule

// File: rtl/ushl_load_unit_chk.sv
module ushl_load_unit_chk #(
  parameter int XLEN   = 32,
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [XLEN-1:0]   mem_req_addr,
  input logic              mem_req_unpriv,
  input logic              mem_rsp_valid,
  input logic [HALF_W-1:0] mem_rsp_data,
  input logic              dst_we,
  input logic [XLEN-1:0]   dst_data,
  input logic              base_we,
  input logic              undef_instr
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R6
  unpriv_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_unpriv);

  // R11
  rsp_to_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |=> dst_we);

  // R11
  base_with_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> dst_we);

  // R5
  sext_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> (dst_data == XLEN'($signed($past(mem_rsp_data)))));

  // R7
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_instr |-> (!mem_req_valid && !dst_we && !base_we));

  // R12
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || dst_we || undef_instr) |-> !instr_ready);
endmodule

bind ushl_load_unit ushl_load_unit_chk #(.XLEN(XLEN), .HALF_W(HALF_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .instr_ready    (instr_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .mem_req_unpriv (mem_req_unpriv),
  .mem_rsp_valid  (mem_rsp_valid),
  .mem_rsp_data   (mem_rsp_data),
  .dst_we         (dst_we),
  .dst_data       (dst_data),
  .base_we        (base_we),
  .undef_instr    (undef_instr)
);

// File: tb/ushl_load_unit_tb.sv
module ushl_load_unit_tb;
  localparam int XLEN = 32;
  localparam int HW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic instr_ready;
  logic [31:0] instr_word = '0;
  logic cond_pass = 1'b0;
  logic hyp_mode = 1'b0;
  logic [3:0] rf_base_idx, rf_index_idx;
  logic [XLEN-1:0] rf_base_data, rf_index_data;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [XLEN-1:0] mem_req_addr;
  logic mem_req_unpriv;
  logic mem_rsp_valid = 1'b0;
  logic [HW-1:0] mem_rsp_data = '0;
  logic dst_we, base_we, undef_instr, retire;
  logic [3:0] dst_idx, base_idx;
  logic [XLEN-1:0] dst_data, base_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int case_no = 0;

  always #10 clk = ~clk;

  function automatic logic [XLEN-1:0] rfv(input logic [3:0] i);
    return ({28'd0, i} * 32'h1111_1111) ^ 32'h0000_0080;
  endfunction

  assign rf_base_data  = rfv(rf_base_idx);
  assign rf_index_data = rfv(rf_index_idx);

  ushl_load_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_word(instr_word),
    .cond_pass(cond_pass), .hyp_mode(hyp_mode),
    .rf_base_idx(rf_base_idx), .rf_base_data(rf_base_data),
    .rf_index_idx(rf_index_idx), .rf_index_data(rf_index_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_unpriv(mem_req_unpriv),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
    .base_we(base_we), .base_idx(base_idx), .base_data(base_data),
    .undef_instr(undef_instr), .retire(retire)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s case=%0d actual=%h expected=%h", req, case_no, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // kind: 0 = no valid layout, 1 = imm post-indexed, 2 = reg post-indexed, 3 = offset form
  task automatic run_case(input logic [31:0] w, input bit cnd, input bit hyp, input int kind);
    logic [3:0] rt, rn, rm;
    logic [7:0] imm;
    logic up, bad;
    logic [XLEN-1:0] off, nxt, exp_addr, exp_data;
    logic [HW-1:0] rd;
    logic [XLEN-1:0] first_addr;
    int n_hs, n_req, rsp_cyc, stall, cyc;
    bit hs_pend, got_undef, got_wr, got_retire, unpriv_ok;
    string areq;

    case_no++;
    rt = w[15:12]; rn = w[19:16]; rm = w[3:0];
    imm = (kind == 3) ? w[7:0] : {w[11:8], w[3:0]};
    up  = (kind == 3) ? 1'b1 : w[23];
    bad = (kind == 0) || hyp
       || ((kind == 1 || kind == 2) && (rt == 15 || rn == 15 || rn == rt))
       || (kind == 2 && rm == 15)
       || (kind == 3 && rt == 15);
    off = (kind == 2) ? rfv(rm) : {24'd0, imm};
    nxt = up ? rfv(rn) + off : rfv(rn) - off;
    exp_addr = (kind == 3) ? nxt : rfv(rn);
    rd = 16'h8001 ^ HW'(case_no * 16'h1357);
    exp_data = {{16{rd[15]}}, rd};
    areq = (kind == 1) ? "R2" : (kind == 2) ? "R3" : "R4";
    stall = case_no % 3;

    @(negedge clk);
    chk(instr_ready == 1'b1, "R12 idle ready", {31'd0, instr_ready}, 32'd1);
    instr_valid = 1'b1; instr_word = w; cond_pass = cnd; hyp_mode = hyp;
    n_hs = 0; n_req = 0; rsp_cyc = -10; hs_pend = 0;
    got_undef = 0; got_wr = 0; got_retire = 0; unpriv_ok = 1; first_addr = '0;
    for (cyc = 0; cyc < 60; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        instr_valid = 1'b0;
        chk(instr_ready == 1'b0, "R12 busy", {31'd0, instr_ready}, 32'd0);
      end
      if (undef_instr) got_undef = 1;
      if (dst_we) begin
        got_wr = 1;
        chk(cyc == rsp_cyc + 1, "R11 write timing", cyc, rsp_cyc + 1);
        chk(dst_idx == rt, "R5 dst index", {28'd0, dst_idx}, {28'd0, rt});
        chk(dst_data == exp_data, "R5 sign extension", dst_data, exp_data);
        chk(base_we == (kind != 3), "R11 writeback enable", {31'd0, base_we}, {31'd0, kind != 3});
        if (kind != 3) begin
          chk(base_idx == rn, {areq, " wb index"}, {28'd0, base_idx}, {28'd0, rn});
          chk(base_data == nxt, {areq, " wb value"}, base_data, nxt);
        end
      end else if (base_we) begin
        chk(1'b0, "R11 base without dst", 32'd1, 32'd0);
      end
      if (hs_pend) begin
        hs_pend = 0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1;
        mem_rsp_data = rd;
        rsp_cyc = cyc;
      end else begin
        mem_rsp_valid = 1'b0;
      end
      if (mem_req_valid) begin
        if (!mem_req_unpriv) unpriv_ok = 0;
        if (n_req == 0) first_addr = mem_req_addr;
        else chk(mem_req_addr == first_addr, "R10 addr hold", mem_req_addr, first_addr);
        n_req++;
        if (stall > 0) begin
          stall--;
          mem_req_ready = 1'b0;
        end else begin
          mem_req_ready = 1'b1;
          hs_pend = 1;
          n_hs++;
        end
      end
      if (retire) begin
        got_retire = 1;
        break;
      end
    end
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    chk(got_retire, "R12 retire seen", {31'd0, got_retire}, 32'd1);
    if (!cnd) begin
      chk(!got_undef && n_req == 0 && !got_wr, "R8 no-op", {29'd0, got_undef, n_req != 0, got_wr}, 32'd0);
    end else if (bad) begin
      chk(got_undef, (kind == 0) ? "R9 undef" : "R7 undef", {31'd0, got_undef}, 32'd1);
      chk(n_req == 0 && !got_wr, "R7 quiet", {30'd0, n_req != 0, got_wr}, 32'd0);
    end else begin
      chk(!got_undef && n_hs == 1 && got_wr, {areq, " executes"}, {29'd0, got_undef, n_hs == 1, got_wr}, 32'd3);
      chk(first_addr == exp_addr, {areq, " address"}, first_addr, exp_addr);
      chk(unpriv_ok, "R6 unpriv", {31'd0, unpriv_ok}, 32'd1);
    end
  endtask

  function automatic logic [31:0] enc_post(input logic [3:0] cnd, input bit regf, input bit u,
                                           input logic [3:0] rn, input logic [3:0] rt, input logic [7:0] imm);
    return {cnd, 3'b000, 1'b0, u, ~regf, 1'b1, 1'b1, rn, rt,
            regf ? 4'h0 : imm[7:4], 4'hF, imm[3:0]};
  endfunction

  function automatic logic [31:0] enc_offs(input logic [3:0] rn, input logic [3:0] rt, input logic [7:0] imm);
    return {12'hF93, rn, rt, 4'hE, imm};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(instr_ready == 1'b1, "R1 ready", {31'd0, instr_ready}, 32'd1);
    chk(!mem_req_valid && !dst_we && !base_we && !undef_instr && !retire, "R1 quiet",
        {27'd0, mem_req_valid, dst_we, base_we, undef_instr, retire}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int rn = 0; rn < 16; rn++) begin
      for (int rt = 0; rt < 16; rt++) begin
        logic [7:0] im;
        im = 8'((rn * 16 + rt) * 7);
        run_case(enc_post(4'(rn % 14), 1'b0, 1'(rn + rt), 4'(rn), 4'(rt), im), 1'b1, 1'b0, 1);
        run_case(enc_post(4'hE, 1'b1, 1'(rn + rt + 1), 4'(rn), 4'(rt), 8'(rn + 2 * rt + 1)),
                 1'b1, 1'b0, 2);
        run_case(enc_offs(4'(rn), 4'(rt), ~im), 1'b1, 1'b0, (rn == 15) ? 0 : 3);
      end
    end

    // R7 hypervisor level on otherwise good words
    run_case(enc_post(4'hE, 1'b0, 1'b1, 4'd2, 4'd3, 8'h10), 1'b1, 1'b1, 1);
    run_case(enc_post(4'h0, 1'b1, 1'b0, 4'd4, 4'd5, 8'h06), 1'b1, 1'b1, 2);
    run_case(enc_offs(4'd1, 4'd2, 8'hFF), 1'b1, 1'b1, 3);

    // R8 condition fail, including words that would otherwise be undefined
    run_case(enc_post(4'hE, 1'b0, 1'b1, 4'd2, 4'd3, 8'h10), 1'b0, 1'b0, 1);
    run_case(enc_post(4'hE, 1'b1, 1'b0, 4'd7, 4'd7, 8'h01), 1'b0, 1'b0, 2);
    run_case(enc_offs(4'd3, 4'd9, 8'h44), 1'b0, 1'b1, 3);
    run_case(32'h0000_0000, 1'b0, 1'b0, 0);

    // R9 malformed layouts
    run_case(enc_post(4'hE, 1'b0, 1'b1, 4'd2, 4'd3, 8'h10) | 32'h0100_0000, 1'b1, 1'b0, 0);
    run_case(enc_post(4'hF, 1'b0, 1'b1, 4'd2, 4'd3, 8'h10), 1'b1, 1'b0, 0);
    run_case(enc_post(4'hE, 1'b1, 1'b1, 4'd2, 4'd3, 8'h01) | 32'h0000_0400, 1'b1, 1'b0, 0);
    run_case(enc_offs(4'd2, 4'd3, 8'h10) & 32'hFFFF_FDFF, 1'b1, 1'b0, 0);
    run_case(enc_post(4'hE, 1'b0, 1'b1, 4'd2, 4'd3, 8'h10) & 32'hFFFF_FFBF, 1'b1, 1'b0, 0);

    finish_run();
  end
endmodule